// File: doc/BRIEF.md
# Ringing-to-Talk Transition Sequencer

This block is a host-side controller for a subscriber line access switch. It takes a line out of the ringing condition and places it in the talk condition. It does this by driving the switch's two mode pins, its latch-enable pin and an open-drain override line. The override line has two levels only. When asserted it pulls the device's all-off input low. When released it leaves the line at high impedance, so that the device's own pull-up and thermal protection stay in charge. The line is never driven high.

Software pulses a start command, picks one of three transition methods and supplies a half-ringing-period hold count in clock cycles. The three methods are:

- **Direct change.** The mode pins move straight from ringing to talk, so the break path closes before the ringing switch opens.
- **Break-before-make via the mode pins.** An all-off code is held on the mode pins for the hold time, then talk is applied.
- **Break-before-make via the override line.** The override is pulled low for the hold time. Talk is set on the mode pins while the override is still low, and the override is released afterwards.

The sequencer reports busy while it runs. It gives a single-cycle done pulse at the end.

Top module: `ring_talk_seq`

## Requirements
- R1: After reset the mode pins are talk (modeRing=0, modeTest=0), the override is released (ovrDriveLow=0), done=0 and busy=0.
- R2: A start command seen while idle makes busy=1 and puts the ringing code (modeRing=1, modeTest=0) on the mode pins from the next cycle on.
- R3: Method 0 (direct change): in the cycle after the ringing code, the mode pins show talk (0,0). The all-off code (1,1) never appears, and the override stays released.
- R4: Method 1 (mode-pin break-before-make): after the ringing code, the mode pins show all-off (1,1) for exactly H cycles and then talk (0,0). The override stays released.
- R5: Method 2 (override break-before-make): after the ringing code, the override is asserted while the mode pins still show ringing (1,0) for exactly H cycles. Then the pins show talk (0,0) for one cycle with the override still asserted. After that the override is released.
- R6: H equals the programmed hold count, except that a hold count of zero gives H=1.
- R7: Method encoding 3 behaves like method 0. The method and the hold count are captured at start, and changes to them during a sequence have no effect.
- R8: A start command while busy is ignored. The running sequence continues unchanged.
- R9: done is high for exactly one cycle, in the cycle after talk is present and the override is released. In the following cycle busy returns to 0.
- R10: latchEn is 0 at all times, so the device latch stays transparent.
- R11: The override is only ever asserted during a method 2 sequence, and it never coincides with the all-off code on the mode pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start a ringing-to-talk transition |
| methodSel | input | 2 | 0 direct, 1 mode-pin break-before-make, 2 override break-before-make, 3 as 0 |
| halfPeriod | input | CNT_W | Half ringing period in clock cycles (0 treated as 1) |
| modeRing | output | 1 | Ringing mode pin to the switch |
| modeTest | output | 1 | Test mode pin to the switch |
| latchEn | output | 1 | Latch enable to the switch, held at 0 |
| ovrDriveLow | output | 1 | 1 pulls the all-off line low, 0 releases it to high impedance |
| done | output | 1 | One-cycle pulse when the transition completes |
| busy | output | 1 | Sequence in progress |

## Verification
The bench targets the following corner cases and the failure each one would expose:

- **Hold count boundaries (zero, one and larger).** A counter that is off by one would lengthen or shorten the all-off or override window. A zero count taken literally would wrap into a very long hold.
- **Override-path ordering.** Talk must be set before the override is released. A design that released the override first, or together with the mode change, would let the break switches close through a stale mode.
- **Start, method and hold changes during a run.** The bench changes all three mid-sequence. A design that sampled them late would switch methods or stretch the hold halfway through.
- **Method code 3 and the idle cycle after done.** These catch a stray all-off code and a done pulse that lasts longer than one cycle.

// File: rtl/rts_pkg.sv
package rts_pkg;

  typedef enum logic [1:0] {
    METH_DIRECT = 2'd0,
    METH_PINS   = 2'd1,
    METH_OVR    = 2'd2
  } method_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RINGING,
    ST_ALLOFF_HOLD,
    ST_SET_TALK,
    ST_RELEASE,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic setRing;
    logic setAllOff;
    logic setTalk;
    logic ovrOn;
    logic ovrOff;
    logic loadCnt;
    logic decCnt;
  } strobe_t;

endpackage

// File: rtl/rts_datapath.sv
module rts_datapath
  import rts_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] halfPeriod,
  output logic             holdLast,
  output logic             modeRing,
  output logic             modeTest,
  output logic             ovrDriveLow,
  output logic             latchEn
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] holdCnt;
  logic [CNT_W-1:0] loadVal;

  assign loadVal  = (halfPeriod == '0) ? ONE : halfPeriod;
  assign holdLast = (holdCnt <= ONE);
  assign latchEn  = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeRing <= 1'b0;
      modeTest <= 1'b0;
    end else if (stb.setRing) begin
      modeRing <= 1'b1;
      modeTest <= 1'b0;
    end else if (stb.setAllOff) begin
      modeRing <= 1'b1;
      modeTest <= 1'b1;
    end else if (stb.setTalk) begin
      modeRing <= 1'b0;
      modeTest <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ovrDriveLow <= 1'b0;
    else if (stb.ovrOn)  ovrDriveLow <= 1'b1;
    else if (stb.ovrOff) ovrDriveLow <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           holdCnt <= ONE;
    else if (stb.loadCnt) holdCnt <= loadVal;
    else if (stb.decCnt)  holdCnt <= holdCnt - ONE;
  end

endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
  import rts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic [1:0] methodSel,
  input  logic       holdLast,
  output strobe_t    stb,
  output logic       done,
  output logic       busy
);

  state_e  state, stateNx;
  method_e methodQ;
  method_e methodDec;

  always_comb begin
    case (methodSel)
      2'd1:    methodDec = METH_PINS;
      2'd2:    methodDec = METH_OVR;
      default: methodDec = METH_DIRECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      methodQ <= METH_DIRECT;
    end else begin
      state <= stateNx;
      if (state == ST_IDLE && startReq) methodQ <= methodDec;
    end
  end

  always_comb begin
    stb     = '0;
    stateNx = state;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          stb.setRing = 1'b1;
          stb.loadCnt = 1'b1;
          stateNx     = ST_RINGING;
        end
      end
      ST_RINGING: begin
        case (methodQ)
          METH_PINS: begin
            stb.setAllOff = 1'b1;
            stateNx       = ST_ALLOFF_HOLD;
          end
          METH_OVR: begin
            stb.ovrOn = 1'b1;
            stateNx   = ST_ALLOFF_HOLD;
          end
          default: begin
            stb.setTalk = 1'b1;
            stateNx     = ST_SET_TALK;
          end
        endcase
      end
      ST_ALLOFF_HOLD: begin
        if (holdLast) begin
          stb.setTalk = 1'b1;
          stateNx     = ST_SET_TALK;
        end else begin
          stb.decCnt = 1'b1;
        end
      end
      ST_SET_TALK: begin
        if (methodQ == METH_OVR) begin
          stb.ovrOff = 1'b1;
          stateNx    = ST_RELEASE;
        end else begin
          stateNx = ST_DONE;
        end
      end
      ST_RELEASE: stateNx = ST_DONE;
      ST_DONE:    stateNx = ST_IDLE;
      default:    stateNx = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);
  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ring_talk_seq.sv
module ring_talk_seq
  import rts_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic [1:0]       methodSel,
  input  logic [CNT_W-1:0] halfPeriod,
  output logic             modeRing,
  output logic             modeTest,
  output logic             latchEn,
  output logic             ovrDriveLow,
  output logic             done,
  output logic             busy
);

  strobe_t stb;
  logic    holdLast;

  rts_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (startReq),
    .methodSel (methodSel),
    .holdLast  (holdLast),
    .stb       (stb),
    .done      (done),
    .busy      (busy)
  );

  rts_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .stb         (stb),
    .halfPeriod  (halfPeriod),
    .holdLast    (holdLast),
    .modeRing    (modeRing),
    .modeTest    (modeTest),
    .ovrDriveLow (ovrDriveLow),
    .latchEn     (latchEn)
  );

endmodule

// File: rtl/ring_talk_seq_chk.sv
module ring_talk_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic startReq,
  input logic busy,
  input logic modeRing,
  input logic modeTest,
  input logic ovrDriveLow,
  input logic done
);

  // R2
  start_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (startReq && !busy) |=> (busy && modeRing && !modeTest));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R9
  done_talk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!modeRing && !modeTest && !ovrDriveLow));

  // R11
  ovr_no_alloff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovrDriveLow |-> !(modeRing && modeTest));

  // R5
  ovr_release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovrDriveLow) |-> (!modeRing && !modeTest && $past(!modeRing && !modeTest)));

  // R11
  ovr_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovrDriveLow |-> busy);

endmodule

bind ring_talk_seq ring_talk_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .startReq    (startReq),
  .busy        (busy),
  .modeRing    (modeRing),
  .modeTest    (modeTest),
  .ovrDriveLow (ovrDriveLow),
  .done        (done)
);

// File: tb/ring_talk_seq_bench.sv
module ring_talk_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             startReq = 1'b0;
  logic [1:0]       methodSel = 2'd0;
  logic [CNT_W-1:0] halfPeriod = '0;
  logic modeRing, modeTest, latchEn, ovrDriveLow, done, busy;

  int testsRun = 0;
  int testsFail = 0;

  // expected item: {modeRing, modeTest, ovrDriveLow, done, busy}
  logic [4:0] expQ[$];
  string      tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_talk_seq #(.CNT_W(CNT_W)) u_ring_talk_seq (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .methodSel(methodSel),
    .halfPeriod(halfPeriod), .modeRing(modeRing), .modeTest(modeTest),
    .latchEn(latchEn), .ovrDriveLow(ovrDriveLow), .done(done), .busy(busy)
  );

  task automatic check(input logic ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
    testsRun++;
    if (!ok) begin
      testsFail++;
      $display("FAIL %s: got {ring,test,ovr,done,busy}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: one expected item per clock, sampled just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [4:0] e;
        logic [4:0] g;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        g = {modeRing, modeTest, ovrDriveLow, done, busy};
        check(g == e, t, g, e);
        // R10 latch enable stays low throughout
        check(latchEn == 1'b0, "R10", {4'b0, latchEn}, 5'b0);
      end
    end
  end

  task automatic runSeq(input logic [1:0] m, input int hold, input int glitchAt, input string tag);
    int n;
    int eff;
    n   = (hold == 0) ? 1 : hold;
    eff = (m == 2'd3) ? 0 : int'(m);
    @(negedge clk);
    startReq   = 1'b1;
    methodSel  = m;
    halfPeriod = CNT_W'(hold);
    push(5'b10001, {tag, "/R2"});
    if (eff == 0) begin
      push(5'b00001, {tag, "/R3"});
    end else if (eff == 1) begin
      for (int i = 0; i < n; i++) push(5'b11001, {tag, "/R4/R6"});
      push(5'b00001, {tag, "/R4"});
    end else begin
      for (int i = 0; i < n; i++) push(5'b10101, {tag, "/R5/R6"});
      push(5'b00101, {tag, "/R5"});
      push(5'b00001, {tag, "/R5"});
    end
    push(5'b00011, {tag, "/R9"});
    push(5'b00000, {tag, "/R9"});
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (k == glitchAt) begin
        startReq   = 1'b1;
        methodSel  = m ^ 2'b11;
        halfPeriod = CNT_W'(hold + 7);
      end else begin
        startReq = 1'b0;
      end
      if (expQ.size() == 0) break;
    end
    startReq = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({modeRing, modeTest, ovrDriveLow, done, busy, latchEn} == 6'b0, "R1",
          {modeRing, modeTest, ovrDriveLow, done, busy}, 5'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({modeRing, modeTest, ovrDriveLow, done, busy} == 5'b0, "R1",
          {modeRing, modeTest, ovrDriveLow, done, busy}, 5'b0);

    runSeq(2'd0, 4, -1, "R3");
    runSeq(2'd1, 3, -1, "R4");
    runSeq(2'd1, 1, -1, "R4");
    runSeq(2'd1, 0, -1, "R6");
    runSeq(2'd2, 5, -1, "R5");
    runSeq(2'd2, 0, -1, "R6");
    runSeq(2'd3, 2, -1, "R7");
    runSeq(2'd1, 4, 1, "R8");
    runSeq(2'd2, 3, 2, "R8");
    runSeq(2'd0, 2, 0, "R8");
    runSeq(2'd2, 2, 3, "R7");

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule